// File: doc/BRIEF.md
# SPI Serial Clock Prescaler and Mode Generator

This block derives the serial clock of an SPI master from the system clock and produces the per-bit strobes that a shift register needs: a shift pulse that launches the next output bit and a sample pulse that captures the next input bit. A 5-bit prescale code selects the divide ratio. The encoding is not linear. When the top bit is clear, the code divides directly. When the top bit is set, the ratio is twice the low four bits, which reaches the even ratios 16 to 30. Clock polarity sets the idle level of the serial clock. Clock phase picks which edge launches data and which edge captures it.

A separate capture-edge select moves input sampling to the opposite serial clock edge. It exists for the shortest divide ratios, where the round trip through the pads leaves too little time before the nominal edge. When the enable is low, the serial clock rests at its idle level and no strobes are issued. When the enable rises, the period counter starts again from zero, so every transfer begins on a clean period boundary. Codes that yield a ratio of 0 or 1 run the serial clock at the system clock rate. The serial clock then follows the inverted system clock, gated by the enable, and the capture-edge select must be set.

Top module: `spi_sclk_gen`

## Requirements
- R1: With bit 4 of the prescale code clear, a code of 1 to 15 gives a serial clock period of that many system clock cycles, and a code of 0 gives a period of 1.
- R2: With bit 4 of the prescale code set, the period is two times bits 3:0 of the code (code 18 gives 4, code 31 gives 30), and a result of 0 (code 16) is treated as a period of 1.
- R3: While the enable is low, or while the reset is asserted, the serial clock equals the polarity input and both the shift and sample pulses are 0. After the enable rises, the period count restarts from its first cycle.
- R4: For a period N of 2 or more, each period starts with floor(N/2) cycles at the idle level, followed by ceil(N/2) cycles at the active (inverted) level. The rising of the active level is the leading edge, and its return to idle is the trailing edge.
- R5: With phase 0, the shift pulse is high in the first cycle of every period, including the first period after the enable rises, and the sample pulse is high in the cycle of the leading edge.
- R6: With phase 1, the shift pulse is high in the cycle of the leading edge, and the sample pulse is high in the cycle of each trailing edge that follows a leading edge. No sample pulse occurs before the first leading edge.
- R7: With the capture-edge select set to 1, the sample pulse moves to the other edge: the trailing edge with phase 0 and the leading edge with phase 1. The shift pulse is unaffected.
- R8: With a period of 1, the serial clock is at the idle level while the system clock is high and at the active level while it is low. The shift pulse is high on every enabled cycle, and the capture-edge select must be 1.
- R9: Polarity 1 inverts the serial clock relative to polarity 0 and has no effect on either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the serial clock while high |
| prescaleCode | input | 5 | Divide ratio code (split encoding) |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on leading edge, 1: shift on leading edge |
| captureFlip | input | 1 | Moves sampling to the opposite edge |
| sclk | output | 1 | Serial clock |
| shiftPulse | output | 1 | One-cycle strobe to launch the next output bit |
| samplePulse | output | 1 | One-cycle strobe to capture the next input bit |

## Verification
The bench builds the block with its default 5-bit code, so the full range of ratios is available: 1, odd and even direct codes, the doubled codes up to 30, and code 16, which collapses to a ratio of 1. A behavioural model tracks the period count and the edge history from the code and the mode bits. It is compared with the serial clock and both strobes on every cycle, across all four phase and capture combinations, both polarities, and an enable that drops in mid period. For a ratio of 1, the low half of each system clock cycle is also checked.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  typedef struct packed {
    logic run;          // generator running this cycle
    logic atStart;      // first cycle of a serial clock period
    logic atLead;       // cycle in which the leading edge occurs
    logic atTrail;      // cycle of a trailing edge that follows a leading edge
    logic activePhase;  // serial clock at its active level (ratio >= 2)
    logic ratioOne;     // divide ratio is 1
  } strobeT;
endpackage

// File: rtl/spi_sclk_ctrl.sv
module spi_sclk_ctrl
  import spi_sclk_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CODE_W-1:0] prescaleCode,
  output strobeT            st
);
  localparam int LOW_W     = CODE_W - 1;
  localparam int MAX_RATIO = 2 * ((1 << LOW_W) - 1);
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);

  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] lowLen;
  logic [CNT_W-1:0] cntQ;
  logic             runQ;
  logic             seenQ;

  // split encoding: direct below the top bit, doubled above it
  always_comb begin
    if (prescaleCode[CODE_W-1])
      ratio = CNT_W'({prescaleCode[LOW_W-1:0], 1'b0});
    else
      ratio = CNT_W'(prescaleCode[LOW_W-1:0]);
    if (ratio == '0)
      ratio = CNT_W'(1);
  end

  assign lowLen = ratio >> 1;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      runQ  <= 1'b0;
      cntQ  <= '0;
      seenQ <= 1'b0;
    end else begin
      runQ  <= 1'b1;
      seenQ <= runQ & (seenQ | st.atLead);
      if (!runQ || cntQ >= ratio - CNT_W'(1))
        cntQ <= '0;
      else
        cntQ <= cntQ + CNT_W'(1);
    end
  end

  always_comb begin
    st.run         = runQ;
    st.atStart     = runQ && (cntQ == '0);
    st.atLead      = runQ && (cntQ == lowLen);
    st.atTrail     = runQ && (cntQ == '0) && seenQ;
    st.activePhase = runQ && (cntQ >= lowLen);
    st.ratioOne    = (ratio == CNT_W'(1));
  end

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> (cntQ == '0));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && $stable(prescaleCode)) |-> (cntQ < ratio));

  // R6
  first_trail_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> !st.atTrail);
endmodule

// File: rtl/spi_sclk_dp.sv
module spi_sclk_dp
  import spi_sclk_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  strobeT st,
  input  logic   cpol,
  input  logic   cpha,
  input  logic   captureFlip,
  output logic   sclk,
  output logic   shiftPulse,
  output logic   samplePulse
);
  logic activeLevel;
  logic sampleOnLead;

  // ratio 1 follows the inverted system clock, gated by run
  assign activeLevel  = st.ratioOne ? (st.run & ~clk) : st.activePhase;
  assign sclk         = cpol ^ activeLevel;
  assign sampleOnLead = (cpha == captureFlip);
  assign shiftPulse   = cpha ? st.atLead : st.atStart;
  assign samplePulse  = sampleOnLead ? st.atLead : st.atTrail;

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.run |-> (sclk == cpol && !shiftPulse && !samplePulse));

  // R6
  split_edges_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpha && !captureFlip && !st.ratioOne && samplePulse) |-> !shiftPulse);

  // R8
  ratio_one_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.run && st.ratioOne) |-> captureFlip);
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CODE_W-1:0] prescaleCode,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              captureFlip,
  output logic              sclk,
  output logic              shiftPulse,
  output logic              samplePulse
);
  strobeT st;

  spi_sclk_ctrl #(.CODE_W(CODE_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .prescaleCode (prescaleCode),
    .st           (st)
  );

  spi_sclk_dp uDp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .cpol        (cpol),
    .cpha        (cpha),
    .captureFlip (captureFlip),
    .sclk        (sclk),
    .shiftPulse  (shiftPulse),
    .samplePulse (samplePulse)
  );
endmodule

// File: tb/sim_spi_sclk_gen.sv
`timescale 1ns/1ps
module sim_spi_sclk_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [4:0] prescaleCode = 5'd4;
  logic cpol = 1'b0, cpha = 1'b0, captureFlip = 1'b0;
  logic sclk, shiftPulse, samplePulse;

  int tests = 0, fails = 0;
  bit finished = 0;

  // model state
  bit mRun = 0, mSeen = 0, mPrevLead = 0;
  int mK = 0;

  always #4 clk = ~clk;

  spi_sclk_gen u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .prescaleCode(prescaleCode),
    .cpol(cpol), .cpha(cpha), .captureFlip(captureFlip),
    .sclk(sclk), .shiftPulse(shiftPulse), .samplePulse(samplePulse)
  );

  function automatic int ratioOf(input logic [4:0] c);
    int r;
    r = c[4] ? 2 * int'(c[3:0]) : int'(c[3:0]);
    return (r == 0) ? 1 : r;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (time %0t)", tag, what, act, exp, $time);
    end
  endtask

  // one clock: update model at the edge, compare 2 ns later
  task automatic step(input string tag);
    int n, half;
    bit lead, trail, expAct, expShift, expSample;
    @(posedge clk);
    n = ratioOf(prescaleCode);
    half = n / 2;
    if (!rstN || !enable) begin
      mRun = 0; mK = 0; mSeen = 0;
    end else if (!mRun) begin
      mRun = 1; mK = 0; mSeen = 0;
    end else begin
      mSeen = mSeen | mPrevLead;
      mK = (mK + 1 >= n) ? 0 : mK + 1;
    end
    lead  = mRun && (mK == half);
    trail = mRun && (mK == 0) && mSeen;
    mPrevLead = lead;
    expAct    = (n == 1) ? 1'b0 : (mRun && mK >= half);  // clk high here
    expShift  = cpha ? lead : (mRun && mK == 0);
    expSample = (cpha == captureFlip) ? lead : trail;
    #2;
    check(tag, "sclk", sclk, cpol ^ expAct);
    check(tag, "shift", shiftPulse, expShift);
    check(tag, "sample", samplePulse, expSample);
    if (n == 1 && mRun) begin
      #4;  // system clock low half
      check({tag, " R8"}, "sclk low half", sclk, ~cpol);
    end
  endtask

  task automatic runCase(input logic [4:0] code, input logic pol, input logic pha,
                         input logic flip, input int cycles, input string tag);
    enable = 0;
    prescaleCode = code; cpol = pol; cpha = pha; captureFlip = flip;
    repeat (2) step({tag, " R3"});
    enable = 1;
    repeat (cycles) step(tag);
    enable = 0;
    repeat (2) step({tag, " R3"});
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R3 reset state, even with enable high
    enable = 1;
    repeat (3) step("R3 reset");
    rstN = 1;
    enable = 0;
    step("R3 idle");
    runCase(5'd4, 0, 0, 0, 20, "R1 R4 R5 code4");
    runCase(5'd5, 0, 0, 0, 22, "R1 R4 odd code5");
    runCase(5'd2, 0, 0, 0, 10, "R1 code2");
    runCase(5'd15, 0, 0, 0, 40, "R1 code15");
    runCase(5'd0, 0, 0, 1, 8, "R1 R8 code0");
    runCase(5'd18, 0, 0, 0, 18, "R2 code18");
    runCase(5'd31, 0, 1, 0, 70, "R2 code31");
    runCase(5'd16, 1, 1, 1, 6, "R2 R8 code16");
    runCase(5'd6, 0, 1, 0, 26, "R6 code6");
    runCase(5'd3, 0, 1, 0, 14, "R6 code3");
    runCase(5'd2, 0, 0, 1, 10, "R7 pha0 flip");
    runCase(5'd4, 0, 1, 1, 16, "R7 pha1 flip");
    runCase(5'd7, 1, 0, 0, 21, "R9 pol1");
    runCase(5'd20, 1, 1, 0, 24, "R9 R2 pol1 code20");
    // R3 enable drop mid period and restart
    prescaleCode = 5'd6; cpol = 0; cpha = 0; captureFlip = 0;
    enable = 1;
    repeat (7) step("R3 pre-drop");
    enable = 0;
    step("R3 drop");
    enable = 1;
    repeat (12) step("R3 restart");
    enable = 0;
    repeat (2) step("R3 end");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule